// File: doc/BRIEF.md
# Alternating Capture Slot Sequencer

This block steers one capture channel that writes frames into two alternating buffer slots, slot P (index 0) and slot B (index 1). Each time the capture engine raises a completion request, the sequencer reads a shared 32-bit status word. It picks out the four flags that belong to its own channel and decides whether the frame is good. A good frame is handed to the host as a done event tagged with the slot and a frame sequence number, and the same slot is then refilled. A bad frame produces a reset request for the channel and returns the sequencer to slot P.

Before trusting a completion, the sequencer compares the slot the engine reports with the slot it expects. It also tracks whether the channel last reported a lost signal, and it checks the FIFO fault flags only while a signal is present. Streaming is opened by a start pulse, which also states which slots already hold a buffer. A stop pulse hands back every loaded slot as errored. Slot occupancy is maintained through a refill handshake: the host answers each refill request with a single bit that says whether a buffer was supplied.

Top module: `pp_capture_seq`

## Requirements
- R1: After reset all pulse outputs are low, and a request that arrives while streaming is off produces no done, refill or reset-request pulse.
- R2: A start pulse clears the sequence number to 0, sets the expected slot to P (0), and loads slot occupancy from start_load_i (bit 0 is slot P, bit 1 is slot B).
- R3: For channel CHAN, the flags are read from fixed status bits: no-signal at bit CHAN, reported slot at bit 8+CHAN, FIFO-bad at bit 16+CHAN and FIFO-overflow at bit 24+CHAN. Bits that belong to other channels have no effect.
- R4: If the channel is in the no-signal state and a request arrives with no-signal clear, the sequencer leaves the no-signal state, pulses rst_req_o, resets the expected slot to P, and delivers nothing.
- R5: If signal is present and FIFO-bad or FIFO-overflow is set, the sequencer pulses rst_req_o, resets the expected slot to P, and delivers nothing.
- R6: While no-signal is set on a request, the FIFO fault flags are ignored.
- R7: If the reported slot differs from the expected slot, the sequencer pulses rst_req_o, resets the expected slot to P, and delivers nothing.
- R8: A good request that finds its slot loaded pulses done_o with that slot and the current sequence number, then increments the sequence and flips the expected slot. In the same cycle it requests a refill of that slot. All of these outputs appear in the cycle after the accepting clock edge.
- R9: A good request that finds its slot empty gives no done pulse and leaves the sequence unchanged, but it still flips the expected slot and requests a refill of that slot.
- R10: When refill_ok_i is high during the cycle in which refill_req_o is high, the refilled slot becomes loaded. When refill_ok_i is low, the slot stays empty.
- R11: A stop pulse gives a one-cycle rel_o with rel_mask_o equal to the loaded slots, empties both slots, and ends streaming.
- R12: A request in the cycle after an accepted request is ignored, so done_o and rst_req_o are each exactly one cycle wide.
- R13: A stop pulse takes priority over a request in the same cycle, and that request is not processed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Open streaming (one-cycle pulse) |
| start_load_i | input | 2 | Slots holding a buffer at start |
| stop_i | input | 1 | Close streaming (one-cycle pulse) |
| req_i | input | 1 | Completion request strobe |
| status_i | input | STAT_W | Shared status word for all channels |
| refill_ok_i | input | 1 | Host supplied a buffer for the refill slot |
| done_o | output | 1 | Buffer delivered |
| done_slot_o | output | 1 | Slot of the delivered buffer |
| done_seq_o | output | SEQ_W | Sequence number of the delivered buffer |
| refill_req_o | output | 1 | Request a buffer for refill_slot_o |
| refill_slot_o | output | 1 | Slot to refill |
| rst_req_o | output | 1 | Channel reset request |
| rel_o | output | 1 | Loaded slots returned as errored |
| rel_mask_o | output | 2 | Slots returned on stop |

## Verification
The assertions assume that start_i and stop_i are one-cycle pulses and that refill_ok_i matters only while refill_req_o is high. Under those assumptions, the pulse-width and pairing properties hold for any req_i pattern. The directed stimulus keeps start and stop to single cycles and holds refill_ok_i only in the answer cycle. It also includes one deliberately held request, so that the spacing rule is exercised without breaking these assumptions.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;
  typedef enum logic [1:0] {
    V_GOOD    = 2'd0,
    V_RECOVER = 2'd1,
    V_FIFO    = 2'd2,
    V_SLOT    = 2'd3
  } verdict_e;

  typedef struct packed {
    logic nosig;
    logic slot;
    logic bad;
    logic ovf;
  } chflags_t;
endpackage

// File: rtl/pp_flag_pick.sv
module pp_flag_pick
  import pp_seq_pkg::*;
#(
  parameter int STAT_W     = 32,
  parameter int CHAN       = 2,
  parameter int NOSIG_BASE = 0,
  parameter int SLOT_BASE  = 8,
  parameter int BAD_BASE   = 16,
  parameter int OVF_BASE   = 24
) (
  input  logic [STAT_W-1:0] status_i,
  output chflags_t          flags_o
);
  localparam int NOSIG_BIT = NOSIG_BASE + CHAN;
  localparam int SLOT_BIT  = SLOT_BASE + CHAN;
  localparam int BAD_BIT   = BAD_BASE + CHAN;
  localparam int OVF_BIT   = OVF_BASE + CHAN;

  always_comb begin
    flags_o.nosig = status_i[NOSIG_BIT];
    flags_o.slot  = status_i[SLOT_BIT];
    flags_o.bad   = status_i[BAD_BIT];
    flags_o.ovf   = status_i[OVF_BIT];
  end
endmodule

// File: rtl/pp_verdict.sv
module pp_verdict
  import pp_seq_pkg::*;
(
  input  chflags_t flags_i,
  input  logic     nosig_q_i,
  input  logic     exp_slot_i,
  output verdict_e verdict_o,
  output logic     nosig_d_o
);
  always_comb begin
    verdict_o = V_GOOD;
    nosig_d_o = flags_i.nosig;
    if (nosig_q_i && !flags_i.nosig) begin
      verdict_o = V_RECOVER;
      nosig_d_o = 1'b0;
    end else if (!flags_i.nosig && (flags_i.bad || flags_i.ovf)) begin
      verdict_o = V_FIFO;
    end else if (flags_i.slot != exp_slot_i) begin
      verdict_o = V_SLOT;
    end
  end
endmodule

// File: rtl/pp_slot_track.sv
module pp_slot_track #(
  parameter int NSLOT = 2,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NSLOT-1:0] start_load_i,
  input  logic             stop_i,
  input  logic             clr_en_i,
  input  logic [SW-1:0]    clr_slot_i,
  input  logic             fill_en_i,
  input  logic [SW-1:0]    fill_slot_i,
  input  logic             fill_ok_i,
  output logic [NSLOT-1:0] loaded_o
);
  logic [NSLOT-1:0] loaded_q;
  logic [NSLOT-1:0] loaded_d;
  logic [NSLOT-1:0] loaded_en;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_comb begin
      loaded_en[s] = 1'b0;
      loaded_d[s]  = loaded_q[s];
      if (stop_i) begin
        loaded_en[s] = 1'b1;
        loaded_d[s]  = 1'b0;
      end else if (start_i) begin
        loaded_en[s] = 1'b1;
        loaded_d[s]  = start_load_i[s];
      end else if (fill_en_i && (fill_slot_i == SW'(s))) begin
        loaded_en[s] = 1'b1;
        loaded_d[s]  = fill_ok_i;
      end else if (clr_en_i && (clr_slot_i == SW'(s))) begin
        loaded_en[s] = 1'b1;
        loaded_d[s]  = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              loaded_q[s] <= 1'b0;
      else if (loaded_en[s])   loaded_q[s] <= loaded_d[s];
    end
  end

  assign loaded_o = loaded_q;

  a_r11_empty_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (loaded_o == '0));
endmodule

// File: rtl/pp_capture_seq.sv
module pp_capture_seq
  import pp_seq_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int CHAN   = 2,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        start_load_i,
  input  logic              stop_i,
  input  logic              req_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              refill_ok_i,
  output logic              done_o,
  output logic              done_slot_o,
  output logic [SEQ_W-1:0]  done_seq_o,
  output logic              refill_req_o,
  output logic              refill_slot_o,
  output logic              rst_req_o,
  output logic              rel_o,
  output logic [1:0]        rel_mask_o
);
  localparam int NSLOT = 2;

  chflags_t   flags;
  verdict_e   verdict;
  logic       nosig_next;
  logic [NSLOT-1:0] loaded;

  logic       stream_q, stream_d;
  logic       exp_q, exp_d;
  logic       nosig_q, nosig_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic       hold_q;
  logic       accept, good, deliver;
  logic       st_en, evt_en;

  pp_flag_pick #(.STAT_W(STAT_W), .CHAN(CHAN)) u_pick (
    .status_i (status_i),
    .flags_o  (flags)
  );

  pp_verdict u_verdict (
    .flags_i    (flags),
    .nosig_q_i  (nosig_q),
    .exp_slot_i (exp_q),
    .verdict_o  (verdict),
    .nosig_d_o  (nosig_next)
  );

  pp_slot_track #(.NSLOT(NSLOT)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_load_i (start_load_i),
    .stop_i       (stop_i),
    .clr_en_i     (deliver),
    .clr_slot_i   (exp_q),
    .fill_en_i    (refill_req_o),
    .fill_slot_i  (refill_slot_o),
    .fill_ok_i    (refill_ok_i),
    .loaded_o     (loaded)
  );

  always_comb begin
    accept  = req_i && stream_q && !hold_q && !stop_i && !start_i;
    good    = (verdict == V_GOOD);
    deliver = accept && good && loaded[exp_q];

    stream_d = stream_q;
    exp_d    = exp_q;
    nosig_d  = nosig_q;
    seq_d    = seq_q;
    if (stop_i) begin
      stream_d = 1'b0;
    end else if (start_i) begin
      stream_d = 1'b1;
      exp_d    = 1'b0;
      seq_d    = '0;
    end else if (accept) begin
      nosig_d = nosig_next;
      exp_d   = good ? ~exp_q : 1'b0;
      if (deliver) seq_d = seq_q + 1'b1;
    end
    st_en  = stop_i || start_i || accept;
    evt_en = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stream_q <= 1'b0;
      exp_q    <= 1'b0;
      nosig_q  <= 1'b0;
      seq_q    <= '0;
    end else if (st_en) begin
      stream_q <= stream_d;
      exp_q    <= exp_d;
      nosig_q  <= nosig_d;
      seq_q    <= seq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q       <= 1'b0;
      done_o       <= 1'b0;
      refill_req_o <= 1'b0;
      rst_req_o    <= 1'b0;
      rel_o        <= 1'b0;
      rel_mask_o   <= '0;
    end else begin
      hold_q       <= accept;
      done_o       <= deliver;
      refill_req_o <= accept && good;
      rst_req_o    <= accept && !good;
      rel_o        <= stop_i;
      rel_mask_o   <= stop_i ? loaded : 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_slot_o   <= 1'b0;
      done_seq_o    <= '0;
      refill_slot_o <= 1'b0;
    end else if (evt_en) begin
      done_slot_o   <= exp_q;
      done_seq_o    <= seq_q;
      refill_slot_o <= exp_q;
    end
  end

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r12_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  a_r5_rst_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (!done_o && !refill_req_o));
  a_r8_refill_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (refill_req_o && (refill_slot_o == done_slot_o)));
  a_r8_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (seq_q == SEQ_W'(done_seq_o + 1'b1)));
  a_r7_back_to_p: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !exp_q);
  a_r11_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o |-> (!stream_q && !done_o));
endmodule

// File: tb/pp_capture_seq_tb.sv
module pp_capture_seq_tb;
  localparam int CH = 2;

  logic clk, rst_n;
  logic start_i, stop_i, req_i, refill_ok_i;
  logic [1:0] start_load_i;
  logic [31:0] status_i;
  logic done_o, done_slot_o, refill_req_o, refill_slot_o, rst_req_o, rel_o;
  logic [15:0] done_seq_o;
  logic [1:0] rel_mask_o;

  int checks = 0;
  int fails  = 0;

  int m_exp, m_seq, m_nosig, m_stream;
  logic [1:0] m_load;

  pp_capture_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_load_i(start_load_i),
    .stop_i(stop_i), .req_i(req_i), .status_i(status_i), .refill_ok_i(refill_ok_i),
    .done_o(done_o), .done_slot_o(done_slot_o), .done_seq_o(done_seq_o),
    .refill_req_o(refill_req_o), .refill_slot_o(refill_slot_o),
    .rst_req_o(rst_req_o), .rel_o(rel_o), .rel_mask_o(rel_mask_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit ns, input bit sl, input bit bd,
                                     input bit ov, input bit noise);
    logic [31:0] w;
    w = noise ? ~(32'h01010101 << CH) : 32'h0;
    w[CH] = ns; w[8+CH] = sl; w[16+CH] = bd; w[24+CH] = ov;
    return w;
  endfunction

  task automatic do_req(input string tag, input bit ns, input bit sl, input bit bd,
                        input bit ov, input bit ok, input bit noise);
    int e_done = 0, e_rst = 0, e_ref = 0, e_slot = 0, e_seq = 0;
    if (m_stream != 0) begin
      if (m_nosig != 0 && !ns) begin
        e_rst = 1; m_nosig = 0; m_exp = 0;
      end else begin
        m_nosig = ns;
        if (!ns && (bd || ov)) begin e_rst = 1; m_exp = 0; end
        else if (int'(sl) != m_exp) begin e_rst = 1; m_exp = 0; end
        else begin
          e_ref = 1; e_slot = m_exp;
          if (m_load[m_exp]) begin e_done = 1; e_seq = m_seq; m_seq++; end
          m_load[m_exp] = ok;
          m_exp = 1 - m_exp;
        end
      end
    end
    @(negedge clk); req_i = 1'b1; status_i = mk(ns, sl, bd, ov, noise);
    @(negedge clk); req_i = 1'b0; refill_ok_i = ok;
    chk({tag, " done"}, int'(done_o), e_done);
    chk({tag, " rst_req"}, int'(rst_req_o), e_rst);
    chk({tag, " refill"}, int'(refill_req_o), e_ref);
    if (e_done != 0) begin
      chk({tag, " done_slot"}, int'(done_slot_o), e_slot);
      chk({tag, " done_seq"}, int'(done_seq_o), e_seq);
    end
    if (e_ref != 0) chk({tag, " refill_slot"}, int'(refill_slot_o), e_slot);
    @(negedge clk); refill_ok_i = 1'b0; status_i = '0;
    chk({tag, " pulse width R12"}, int'(done_o | rst_req_o), 0);
  endtask

  task automatic do_start(input logic [1:0] ld);
    @(negedge clk); start_i = 1'b1; start_load_i = ld;
    @(negedge clk); start_i = 1'b0; start_load_i = 2'b00;
    m_stream = 1; m_seq = 0; m_exp = 0; m_load = ld;
    chk("R2 start quiet", int'(done_o | rst_req_o | refill_req_o), 0);
  endtask

  task automatic do_stop(input bit with_req);
    @(negedge clk); stop_i = 1'b1;
    if (with_req) begin req_i = 1'b1; status_i = mk(0, m_exp[0], 0, 0, 0); end
    @(negedge clk); stop_i = 1'b0; req_i = 1'b0; status_i = '0;
    chk("R11 rel pulse", int'(rel_o), 1);
    chk("R11 rel mask", int'(rel_mask_o), int'(m_load));
    chk("R13 no done on stop", int'(done_o | rst_req_o | refill_req_o), 0);
    m_load = 2'b00; m_stream = 0;
    @(negedge clk);
    chk("R11 rel one cycle", int'(rel_o), 0);
  endtask

  task automatic t_reset;
    chk("R1 reset done", int'(done_o), 0);
    chk("R1 reset rst_req", int'(rst_req_o), 0);
    chk("R1 reset refill", int'(refill_req_o), 0);
    chk("R1 reset rel", int'(rel_o), 0);
    do_req("R1 idle request", 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_good;
    do_start(2'b11);
    do_req("R8 good P", 0, 0, 0, 0, 1, 0);
    do_req("R8 good B", 0, 1, 0, 0, 1, 0);
    do_req("R3 noise ignored", 0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_mismatch;
    do_req("R7 slot mismatch", 0, 0, 0, 0, 1, 0);
    do_req("R7 back to P", 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_empty;
    do_req("R10 refill refused", 0, 1, 0, 0, 0, 0);
    do_req("R8 good P again", 0, 0, 0, 0, 1, 0);
    do_req("R9 empty slot B", 0, 1, 0, 0, 1, 0);
    do_req("R9 seq held", 0, 0, 0, 0, 1, 0);
    do_req("R10 slot B reloaded", 0, 1, 0, 0, 1, 0);
  endtask

  task automatic t_fifo;
    do_req("R5 overflow", 0, 0, 0, 1, 1, 0);
    do_req("R5 bad", 0, 0, 1, 0, 1, 0);
    do_req("R5 resume P", 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_nosig;
    do_req("R6 faults masked", 1, 1, 1, 1, 1, 0);
    do_req("R4 recovery", 0, 0, 0, 0, 1, 0);
    do_req("R4 resume P", 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_spacing;
    int e_seq;
    e_seq = m_seq;
    @(negedge clk); req_i = 1'b1; status_i = mk(0, m_exp[0], 0, 0, 0);
    @(negedge clk); refill_ok_i = 1'b1;
    chk("R12 first accepted", int'(done_o), 1);
    chk("R12 first seq", int'(done_seq_o), e_seq);
    @(negedge clk); req_i = 1'b0; refill_ok_i = 1'b0; status_i = '0;
    chk("R12 second ignored", int'(done_o | rst_req_o | refill_req_o), 0);
    @(negedge clk);
    chk("R12 still quiet", int'(done_o | rst_req_o | refill_req_o), 0);
    m_seq++; m_exp = 1 - m_exp;
  endtask

  task automatic t_stop;
    do_stop(1'b1);
    do_req("R11 ignored after stop", 0, 0, 0, 0, 1, 0);
    do_start(2'b10);
    do_req("R2 slot P empty at start", 0, 0, 0, 0, 0, 0);
    do_req("R2 slot B loaded seq0", 0, 1, 0, 0, 1, 0);
    do_stop(1'b0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 0; stop_i = 0; req_i = 0; refill_ok_i = 0;
    start_load_i = 2'b00; status_i = '0;
    m_exp = 0; m_seq = 0; m_nosig = 0; m_stream = 0; m_load = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_mismatch();
    t_empty();
    t_fifo();
    t_nosig();
    t_spacing();
    t_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule